// File: doc/BRIEF.md
# Configurable Status Pin Output Generator

This block drives one status pin for a flash device whose internal write engine runs program and erase jobs. After reset the pin is a level ready/busy line: it is pulled low while the engine is working and is high when the engine is idle or suspended. A two-write configuration command can turn the pin into an interrupt source instead. In that form the pin rests high and drops for a fixed number of clocks when an enabled kind of operation finishes.

The first write of the command carries the setup byte B8h. The next write carries a two-bit code. Code bit 0 enables pulses for finished erases and code bit 1 enables pulses for finished programs. Code 00h brings back the level line. The command is honoured only while the engine is neither busy nor suspended. A code above 03h is refused and raises two error bits, which feed bits 4 and 5 of the device status register. Those error bits are cleared by writing the clear-status byte 50h. Operations that set or clear lock bits never produce a pulse.

Top module: `status_pin_gen`

## Requirements
- R1: A clock edge with `rst_n` low puts the pin high, clears both error bits and selects level mode.
- R2: In level mode, `stat_pin` is low in the cycle after an edge that samples `eng_busy` high with `eng_susp` low, and high after an edge that samples the engine idle or suspended.
- R3: When a write of B8h is followed by a write of a code with bit 0 set (01h or 03h), pulse mode is selected. In that mode an edge that samples `erase_done` high drives `stat_pin` low for exactly PULSE_LEN cycles, starting with the next cycle.
- R4: Code bit 1 (codes 02h and 03h) enables the same pulse for `prog_done`. A completion whose enable bit is clear leaves the pin high.
- R5: The confirm code 00h brings back level mode.
- R6: A confirm write made while `eng_busy` or `eng_susp` is high changes neither the mode nor the error bits.
- R7: A confirm code above 03h, accepted while the engine is idle, sets both bits of `sr_err` to 1 and leaves the mode unchanged.
- R8: The error bits stay set until a write of 50h that is not the confirm write of a configuration command. A 50h sent as a confirm code counts as an invalid code.
- R9: A completion sampled while `lock_op` is high produces no pulse.
- R10: In pulse mode the pin does not follow `eng_busy` and stays high when no pulse is running.
- R11: A write that is not part of a configuration command and is neither B8h nor 50h has no effect.
- R12: A new enabled completion during a running pulse restarts the pulse, so the pin stays low for PULSE_LEN cycles after the last such completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (device reset pin) |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_data | input | 8 | Bus write data |
| eng_busy | input | 1 | Write engine is running a job |
| eng_susp | input | 1 | Write engine is suspended |
| prog_done | input | 1 | One-cycle flag: a program job has finished |
| erase_done | input | 1 | One-cycle flag: an erase job has finished |
| lock_op | input | 1 | The job that is finishing is a lock-bit set or clear |
| stat_pin | output | 1 | Status pin, either a level ready/busy line or active-low pulses |
| sr_err | output | 2 | Error bits for status register bits 4 (index 0) and 5 (index 1) |

## Verification
Both outputs come from registers and are driven by nothing else, so every result is due in the cycle right after the edge that samples its stimulus. A pulse spans that cycle and the following PULSE_LEN-1 cycles. The bench drives inputs on falling edges. For each driven cycle it queues the expected pin and error values tagged with the cycle in which they fall due. A monitor pops each item on the falling edge of that cycle, half a period after the outputs have settled. Each pulse length and each restarted pulse is therefore checked one cycle at a time.

// File: rtl/spg_pkg.sv
// Package spg_pkg: the command bytes and the code width shared by the
// status-pin generator modules. It assumes an 8-bit write data bus.
package spg_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned CODE_W   = 2;
    localparam logic [DATA_W-1:0] CMD_SETUP = 8'hB8;
    localparam logic [DATA_W-1:0] CMD_CLEAR = 8'h50;
    typedef logic [CODE_W-1:0] pin_cfg_t;
    localparam pin_cfg_t CFG_LEVEL = '0;
endpackage

// File: rtl/spg_cmd_decode.sv
// spg_cmd_decode: follows the two-write configuration command and the
// clear-status write. Its outputs are one-cycle strobes. The module assumes
// that each bus write asserts wr_en for a single cycle. Whatever write
// follows a setup byte is taken as the confirm write.
module spg_cmd_decode
    import spg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_susp,
    output logic              cfg_load,
    output pin_cfg_t          cfg_code,
    output logic              err_set,
    output logic              err_clr
);
    logic pend_q;
    logic confirm;
    logic idle_ok;
    logic code_ok;

    // Remember that a setup byte arrived and that the next write is its confirm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (wr_en)
            pend_q <= !pend_q && (wr_data == CMD_SETUP);
    end

    // Classify the current write into load, error or clear strobes.
    always_comb begin
        confirm  = wr_en && pend_q;
        idle_ok  = !eng_busy && !eng_susp;
        code_ok  = (wr_data[DATA_W-1:CODE_W] == '0);
        cfg_code = wr_data[CODE_W-1:0];
        cfg_load = confirm && idle_ok && code_ok;
        err_set  = confirm && idle_ok && !code_ok;
        err_clr  = wr_en && !pend_q && (wr_data == CMD_CLEAR);
    end
endmodule

// File: rtl/spg_cfg_regs.sv
// spg_cfg_regs: holds the selected pin mode and the sticky error bits.
// It assumes that err_set and err_clr are never high in the same cycle.
// The decoder guarantees this, and err_set still takes priority if they are.
module spg_cfg_regs
    import spg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_load,
    input  pin_cfg_t cfg_code,
    input  logic     err_set,
    input  logic     err_clr,
    output pin_cfg_t mode_q,
    output logic [1:0] err_q
);
    // Load a new mode only when the decoder accepts a confirm write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= CFG_LEVEL;
        else if (cfg_load)
            mode_q <= cfg_code;
    end

    // Set both error bits on an invalid code and drop them on clear-status.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 2'b00;
        else if (err_set)
            err_q <= 2'b11;
        else if (err_clr)
            err_q <= 2'b00;
    end
endmodule

// File: rtl/spg_pulse_timer.sv
// spg_pulse_timer: counts out a pulse of PULSE_LEN cycles. It starts one
// cycle after fire is sampled, and a new fire reloads the count. It assumes
// PULSE_LEN >= 1. The clr input wins over fire.
module spg_pulse_timer #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt_q;

    // Reload on fire, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // The pulse is running while the counter is non-zero.
    assign active = (cnt_q != '0);
endmodule

// File: rtl/status_pin_gen.sv
// status_pin_gen: drives the status pin either as a level ready/busy line or
// as active-low completion pulses, and reports invalid configuration codes.
// It assumes that prog_done and erase_done are one-cycle flags and that
// lock_op is valid in the same cycle as those flags.
module status_pin_gen
    import spg_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_susp,
    input  logic              prog_done,
    input  logic              erase_done,
    input  logic              lock_op,
    output logic              stat_pin,
    output logic [1:0]        sr_err
);
    logic     cfg_load;
    pin_cfg_t cfg_code;
    logic     err_set;
    logic     err_clr;
    pin_cfg_t mode_q;
    logic     pulse_on;
    logic     fire;
    logic     ready_q;

    spg_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_susp(eng_susp),
        .cfg_load(cfg_load), .cfg_code(cfg_code),
        .err_set(err_set), .err_clr(err_clr)
    );

    spg_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
        .err_set(err_set), .err_clr(err_clr),
        .mode_q(mode_q), .err_q(sr_err)
    );

    // Fire on an enabled completion of a job that is not a lock-bit job.
    always_comb begin
        fire = !lock_op && ((erase_done && mode_q[0]) || (prog_done && mode_q[1]));
    end

    spg_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr(cfg_load), .active(pulse_on)
    );

    // Register the level ready/busy value. A suspended engine counts as ready.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b1;
        else
            ready_q <= !(eng_busy && !eng_susp);
    end

    // Choose the pin source from the current mode.
    assign stat_pin = (mode_q == CFG_LEVEL) ? ready_q : !pulse_on;
endmodule

// File: rtl/spg_checker.sv
// spg_checker: timing properties of the status-pin generator. It is bound
// to every instance of status_pin_gen and sees the mode and pulse state.
module spg_checker
    import spg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic       eng_busy,
    input logic       eng_susp,
    input logic       prog_done,
    input logic       erase_done,
    input logic       lock_op,
    input logic       stat_pin,
    input logic [1:0] sr_err,
    input pin_cfg_t   mode,
    input logic       pulse_on
);
    // Level mode: a busy engine pulls the pin low one cycle later.
    assert_busy_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CFG_LEVEL && eng_busy && !eng_susp) |=> !stat_pin);

    // An enabled erase completion starts a pulse.
    assert_erase_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] && erase_done && !lock_op && !wr_en) |=> !stat_pin);

    // An enabled program completion starts a pulse.
    assert_prog_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && prog_done && !lock_op && !wr_en) |=> !stat_pin);

    // A busy or suspended engine blocks any change of mode.
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy || eng_susp) |=> $stable(mode));

    // The error bits only fall on a clear-status write.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_err != 2'b00 && !(wr_en && wr_data == CMD_CLEAR)) |=> (sr_err != 2'b00));

    // A lock-bit completion does not start a pulse from idle.
    assert_lock_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CFG_LEVEL && lock_op && !pulse_on && !wr_en) |=> stat_pin);

    // Pulse mode ignores busy: the pin stays high while no completion occurs.
    assert_pulse_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CFG_LEVEL && !pulse_on && !wr_en && !prog_done && !erase_done)
        |=> stat_pin);
endmodule

bind status_pin_gen spg_checker chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_susp(eng_susp), .prog_done(prog_done),
    .erase_done(erase_done), .lock_op(lock_op), .stat_pin(stat_pin),
    .sr_err(sr_err), .mode(mode_q), .pulse_on(pulse_on)
);

// File: tb/status_pin_gen_tb_top.sv
// Scoreboard bench: the driver queues the value expected one cycle after
// each driven cycle, and a monitor on the falling edge compares it.
module status_pin_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       eng_busy = 1'b0;
    logic       eng_susp = 1'b0;
    logic       prog_done = 1'b0;
    logic       erase_done = 1'b0;
    logic       lock_op = 1'b0;
    logic       stat_pin;
    logic [1:0] sr_err;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic       pin;
        logic [1:0] err;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    status_pin_gen #(.PULSE_LEN(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .eng_busy(eng_busy), .eng_susp(eng_susp), .prog_done(prog_done),
        .erase_done(erase_done), .lock_op(lock_op),
        .stat_pin(stat_pin), .sr_err(sr_err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Drive one cycle of inputs and queue the outputs due after the next edge.
    task automatic drv(input logic r, input logic w, input logic [7:0] d,
                       input logic b, input logic s, input logic p,
                       input logic e, input logic l,
                       input logic ep, input logic [1:0] ee, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = r; wr_en = w; wr_data = d; eng_busy = b; eng_susp = s;
        prog_done = p; erase_done = e; lock_op = l;
        it.due = cyc + 1; it.pin = ep; it.err = ee; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input logic ep, input logic [1:0] ee, input string tag);
        drv(1, 0, 8'h00, 0, 0, 0, 0, 0, ep, ee, tag);
    endtask

    task automatic wr(input logic [7:0] d, input logic ep, input logic [1:0] ee, input string tag);
        drv(1, 1, d, 0, 0, 0, 0, 0, ep, ee, tag);
    endtask

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            n_chk++;
            if (stat_pin !== sb_q[0].pin || sr_err !== sb_q[0].err) begin
                n_fail++;
                $display("FAIL %s: pin=%b err=%b expected pin=%b err=%b",
                         sb_q[0].tag, stat_pin, sr_err, sb_q[0].pin, sb_q[0].err);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: state after reset
        idle(1, 2'b00, "R1 reset state");
        // R2: level ready/busy
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R2 busy low");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R2 busy held");
        drv(1, 0, 8'h00, 1, 1, 0, 0, 0, 1, 2'b00, "R2 suspended high");
        idle(1, 2'b00, "R2 idle high");
        // R11: unrelated writes are ignored
        wr(8'h12, 1, 2'b00, "R11 stray write");
        wr(8'h01, 1, 2'b00, "R11 code without setup");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R11 still level mode");
        // R6: confirm while busy or suspended is rejected
        wr(8'hB8, 1, 2'b00, "R6 setup");
        drv(1, 1, 8'h01, 1, 0, 0, 0, 0, 0, 2'b00, "R6 confirm while busy");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R6 level kept");
        wr(8'hB8, 1, 2'b00, "R6 setup again");
        drv(1, 1, 8'h07, 1, 1, 0, 0, 0, 1, 2'b00, "R6 bad code while suspended no error");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R6 level kept after suspend");
        // R7: invalid code sets both error bits
        wr(8'hB8, 1, 2'b00, "R7 setup");
        wr(8'h07, 1, 2'b11, "R7 invalid code");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b11, "R7 mode unchanged");
        // R8: sticky errors, 50h as confirm does not clear
        wr(8'hB8, 1, 2'b11, "R8 setup");
        wr(8'h50, 1, 2'b11, "R8 50h as code stays set");
        idle(1, 2'b11, "R8 sticky");
        wr(8'h50, 1, 2'b00, "R8 clear status");
        // R3: erase pulse with code 01h
        wr(8'hB8, 1, 2'b00, "R3 setup");
        wr(8'h01, 1, 2'b00, "R3 confirm 01");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 1, 2'b00, "R10 busy ignored");
        drv(1, 0, 8'h00, 0, 0, 0, 1, 0, 0, 2'b00, "R3 pulse cycle 1");
        idle(0, 2'b00, "R3 pulse cycle 2");
        idle(0, 2'b00, "R3 pulse cycle 3");
        idle(0, 2'b00, "R3 pulse cycle 4");
        idle(1, 2'b00, "R3 pulse ended");
        drv(1, 0, 8'h00, 0, 0, 1, 0, 0, 1, 2'b00, "R4 program disabled by 01");
        // R9: lock commands give no pulse
        drv(1, 0, 8'h00, 0, 0, 0, 1, 1, 1, 2'b00, "R9 lock erase no pulse");
        idle(1, 2'b00, "R9 quiet");
        // R4: program pulse with code 02h
        wr(8'hB8, 1, 2'b00, "R4 setup");
        wr(8'h02, 1, 2'b00, "R4 confirm 02");
        drv(1, 0, 8'h00, 0, 0, 1, 0, 0, 0, 2'b00, "R4 pulse cycle 1");
        idle(0, 2'b00, "R4 pulse cycle 2");
        idle(0, 2'b00, "R4 pulse cycle 3");
        idle(0, 2'b00, "R4 pulse cycle 4");
        idle(1, 2'b00, "R4 pulse ended");
        drv(1, 0, 8'h00, 0, 0, 0, 1, 0, 1, 2'b00, "R4 erase disabled by 02");
        drv(1, 0, 8'h00, 0, 0, 1, 0, 1, 1, 2'b00, "R9 lock program no pulse");
        // R12: retrigger with code 03h
        wr(8'hB8, 1, 2'b00, "R12 setup");
        wr(8'h03, 1, 2'b00, "R12 confirm 03");
        drv(1, 0, 8'h00, 0, 0, 0, 1, 0, 0, 2'b00, "R12 erase pulse");
        drv(1, 0, 8'h00, 0, 0, 1, 0, 0, 0, 2'b00, "R12 program restarts");
        idle(0, 2'b00, "R12 restarted 2");
        idle(0, 2'b00, "R12 restarted 3");
        idle(0, 2'b00, "R12 restarted 4");
        idle(1, 2'b00, "R12 pulse ended");
        // R6 in pulse mode: rejected 00h keeps pulse mode
        wr(8'hB8, 1, 2'b00, "R6 setup pulse mode");
        drv(1, 1, 8'h00, 1, 0, 0, 0, 0, 1, 2'b00, "R6 busy confirm rejected");
        drv(1, 0, 8'h00, 0, 0, 0, 1, 0, 0, 2'b00, "R6 still pulse mode");
        idle(0, 2'b00, "R6 pulse 2");
        idle(0, 2'b00, "R6 pulse 3");
        idle(0, 2'b00, "R6 pulse 4");
        idle(1, 2'b00, "R6 pulse ended");
        // R5: code 00h returns to level mode
        wr(8'hB8, 1, 2'b00, "R5 setup");
        wr(8'h00, 1, 2'b00, "R5 confirm 00");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R5 level busy low");
        idle(1, 2'b00, "R5 level ready");
        // R1: reset in the middle of operation
        wr(8'hB8, 1, 2'b00, "R1 setup");
        wr(8'h02, 1, 2'b00, "R1 pulse mode");
        wr(8'hB8, 1, 2'b00, "R1 setup bad");
        wr(8'h0A, 1, 2'b11, "R1 error set");
        drv(0, 0, 8'h00, 1, 0, 0, 0, 0, 1, 2'b00, "R1 reset clears");
        drv(1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 2'b00, "R1 level mode after reset");
        idle(1, 2'b00, "R1 ready after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule